// File: doc/BRIEF.md
# Interrupt Status Register with Clear and Set Aliases

This block keeps a bank of interrupt status bits behind a small register bus. Each bit is raised by a pulse on its hardware event input and stays raised until software clears it. Software clears bits by writing ones to the status address, and it can raise bits itself by writing ones to a second address that aliases the same status bits. A mask register, written over the same bus, selects which status bits may reach the single interrupt line. The interrupt line is high whenever any status bit is set together with its mask bit.

The bus has a chip select, a write strobe, a byte address, write data, byte enables and an acknowledge. The master holds chip select for two cycles. The block returns a one-cycle acknowledge in the second cycle and registers read data on the same edge. Clear, set and mask writes take effect only on the edge that closes the acknowledge cycle, so one access produces exactly one side effect. Hardware events are sampled on every clock edge, including during bus accesses, and they take priority over a software clear of the same bit.

Top module: `irq_status_block`

## Requirements
- R1: A synchronous active-high `rst` clears every status and mask bit and drives `bus_ack`, `bus_rdata` and `irq` to zero.
- R2: When `bus_cs` is high and `bus_ack` is low at a rising edge, `bus_ack` is high for exactly the following cycle and then low again.
- R3: Only exact byte addresses decode. Address 0x00 is the status register, 0x04 is the set alias and 0x08 is the mask. Reads of 0x00 and 0x04 both return the status value, and a read of 0x08 returns the mask. Any other address reads as zero. The read data is registered on the edge that raises `bus_ack`.
- R4: A write to 0x00 clears each status bit whose write-data bit is 1 and whose byte lane is enabled. `bus_be[k]` covers data bits 8k+7 down to 8k. Zero bits and disabled lanes leave status unchanged.
- R5: A write to 0x04 sets each status bit whose write-data bit is 1, whatever the byte enables are. Zero bits have no effect.
- R6: A 1 on `hw_evt[i]` at a rising edge sets status bit i, whether or not a bus access is in progress.
- R7: When a hardware event and a software clear reach the same bit on the same edge, the bit ends up set.
- R8: Clear, set and mask writes take effect only on the edge where `bus_cs`, `bus_wr` and `bus_ack` are all high. The first cycle of an access changes no state.
- R9: A write to 0x08 updates only the mask bytes whose byte enables are high.
- R10: `irq` is high exactly when some bit is set in both the status and the mask.
- R11: A write to an address that does not decode changes neither the status nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs | input | 1 | Chip select, held for two cycles per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_be | input | DATA_W/8 | Byte enables |
| bus_rdata | output | DATA_W | Registered read data |
| bus_ack | output | 1 | One-cycle acknowledge |
| hw_evt | input | DATA_W | Hardware event pulses, one per status bit |
| irq | output | 1 | Masked OR of the status bits |

## Verification
The hardest case to reach is a hardware event that lands on the exact edge where a software clear of the same bit commits, because that edge is the second cycle of a bus access. The bench access task drives the event inputs separately for the first and second cycles of each access. A directed case places the event on the commit edge of a full clear, and random accesses draw separate sparse event patterns for both cycles. The interrupt line is also sampled after the first cycle of every access, which shows that no write takes effect early.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_SET  = 2'd2,
    SEL_MASK = 2'd3
  } sel_e;
endpackage

// File: rtl/irq_bus_port.sv
module irq_bus_port
  import irq_status_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int BE_W   = DATA_W / 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h00,
  parameter logic [ADDR_W-1:0] SET_OFS  = 'h04,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'h08
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BE_W-1:0]   be,
  input  logic [DATA_W-1:0] stat,
  input  logic [DATA_W-1:0] mask,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] clr,
  output logic [DATA_W-1:0] set,
  output logic [BE_W-1:0]   mask_we
);
  sel_e              sel;
  logic              commit;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    if (addr == STAT_OFS)      sel = SEL_STAT;
    else if (addr == SET_OFS)  sel = SEL_SET;
    else if (addr == MASK_OFS) sel = SEL_MASK;
    else                       sel = SEL_NONE;
  end

  always_comb begin
    case (sel)
      SEL_STAT, SEL_SET: rd_mux = stat;
      SEL_MASK:          rd_mux = mask;
      default:           rd_mux = '0;
    endcase
  end

  // second cycle of a write access: the only place side effects happen
  assign commit = cs & wr & ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack   <= 1'b0;
      rdata <= '0;
    end else if (cs && !ack) begin
      ack   <= 1'b1;
      rdata <= rd_mux;
    end else begin
      ack   <= 1'b0;
    end
  end

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign clr[b*8 +: 8] = (commit && sel == SEL_STAT && be[b]) ? wdata[b*8 +: 8] : 8'h00;
    assign mask_we[b]    = commit && sel == SEL_MASK && be[b];
  end

  assign set = (commit && sel == SEL_SET) ? wdata : '0;
endmodule

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] evt,
  input  logic [DATA_W-1:0] clr,
  input  logic [DATA_W-1:0] set,
  output logic [DATA_W-1:0] stat
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) stat[i] <= 1'b0;
      else     stat[i] <= (stat[i] & ~clr[i]) | evt[i] | set[i];
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BE_W-1:0]   we,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);
  for (genvar b = 0; b < BE_W; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)       q[b*8 +: 8] <= 8'h00;
      else if (we[b]) q[b*8 +: 8] <= din[b*8 +: 8];
    end
  end
endmodule

// File: rtl/irq_status_block.sv
module irq_status_block #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [BE_W-1:0]   bus_be,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  input  logic [DATA_W-1:0] hw_evt,
  output logic              irq
);
  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] clr_v;
  logic [DATA_W-1:0] set_v;
  logic [BE_W-1:0]   mask_we;

  irq_bus_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BE_W(BE_W)) u_port (
    .clk(clk), .rst(rst), .cs(bus_cs), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .be(bus_be), .stat(stat_q), .mask(mask_q),
    .ack(bus_ack), .rdata(bus_rdata), .clr(clr_v), .set(set_v), .mask_we(mask_we)
  );

  irq_stat_bank #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst(rst), .evt(hw_evt), .clr(clr_v), .set(set_v), .stat(stat_q)
  );

  irq_mask_reg #(.DATA_W(DATA_W), .BE_W(BE_W)) u_mask (
    .clk(clk), .rst(rst), .we(mask_we), .din(bus_wdata), .q(mask_q)
  );

  assign irq = |(stat_q & mask_q);
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cs,
  input logic              wr,
  input logic              ack,
  input logic [DATA_W-1:0] evt,
  input logic [DATA_W-1:0] stat,
  input logic [DATA_W-1:0] mask
);
  // R2
  ack_single_chk: assert property (@(posedge clk) disable iff (rst) ack |=> !ack);
  // R2
  ack_follows_cs_chk: assert property (@(posedge clk) disable iff (rst) (cs && !ack) |=> ack);
  // R6 R7
  evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((stat & $past(evt)) == $past(evt)));
  // R8
  stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(cs && wr && ack) && evt == '0) |=> $stable(stat));
  // R8 R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(cs && wr && ack) |=> $stable(mask));
endmodule

bind irq_status_block irq_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cs(bus_cs), .wr(bus_wr), .ack(bus_ack),
  .evt(hw_evt), .stat(stat_q), .mask(mask_q)
);

// File: tb/irq_status_block_tb.sv
`timescale 1ns/1ps
module irq_status_block_tb;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int BW = DW / 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_cs = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [BW-1:0] bus_be = '0;
  logic [DW-1:0] bus_rdata;
  logic          bus_ack;
  logic [DW-1:0] hw_evt = '0;
  logic          irq;

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] m_stat = '0;
  logic [DW-1:0] m_mask = '0;
  logic [DW-1:0] rd_val;

  always #5 clk = ~clk;

  irq_status_block #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .hw_evt(hw_evt), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rd_model(input logic [AW-1:0] a);
    if (a == 8'h00 || a == 8'h04) return m_stat;
    if (a == 8'h08) return m_mask;
    return '0;
  endfunction

  function automatic logic [DW-1:0] lane_bits(input logic [BW-1:0] be);
    logic [DW-1:0] r;
    for (int k = 0; k < BW; k++) r[k*8 +: 8] = {8{be[k]}};
    return r;
  endfunction

  // two-cycle access; ev1 in the first cycle, ev2 on the commit edge
  task automatic access(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [BW-1:0] be, input logic [DW-1:0] ev1,
                        input logic [DW-1:0] ev2, output logic [DW-1:0] rd);
    logic [DW-1:0] exp_rd;
    @(negedge clk);
    bus_cs = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d; bus_be = be; hw_evt = ev1;
    exp_rd = rd_model(a);
    @(posedge clk);
    m_stat = m_stat | ev1;
    #1;
    chk(bus_ack === 1'b1, "R2 ack after cs", {31'd0, bus_ack}, 1);
    chk(bus_rdata === exp_rd, "R3 read data", bus_rdata, exp_rd);
    chk(irq === |(m_stat & m_mask), "R8 no effect in first cycle", {31'd0, irq}, {31'd0, |(m_stat & m_mask)});
    rd = bus_rdata;
    @(negedge clk);
    hw_evt = ev2;
    @(posedge clk);
    if (w && a == 8'h00) m_stat = m_stat & ~(d & lane_bits(be));
    if (w && a == 8'h04) m_stat = m_stat | d;
    m_stat = m_stat | ev2;
    if (w && a == 8'h08) m_mask = (m_mask & ~lane_bits(be)) | (d & lane_bits(be));
    #1;
    chk(bus_ack === 1'b0, "R2 ack single cycle", {31'd0, bus_ack}, 0);
    chk(irq === |(m_stat & m_mask), "R10 irq", {31'd0, irq}, {31'd0, |(m_stat & m_mask)});
    @(negedge clk);
    bus_cs = 1'b0; bus_wr = 1'b0; hw_evt = '0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input string req);
    logic [DW-1:0] exp;
    logic [DW-1:0] got;
    exp = rd_model(a);
    access(1'b0, a, '0, '0, '0, '0, got);
    chk(got === exp, req, got, exp);
  endtask

  task automatic idle(input logic [DW-1:0] e);
    @(negedge clk);
    hw_evt = e;
    @(posedge clk);
    m_stat = m_stat | e;
    #1;
    chk(irq === |(m_stat & m_mask), "R6 event while idle", {31'd0, irq}, {31'd0, |(m_stat & m_mask)});
    @(negedge clk);
    hw_evt = '0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] tmp;
    process::self().srandom(32'd1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(bus_ack === 1'b0 && bus_rdata === '0 && irq === 1'b0, "R1 reset outputs", bus_rdata, '0);
    rd_chk(8'h00, "R1 status zero after reset");
    rd_chk(8'h08, "R1 mask zero after reset");

    // R5: set alias ignores byte enables
    access(1'b1, 8'h04, 32'hA5A5_0001, 4'b0000, '0, '0, tmp);
    rd_chk(8'h00, "R5 set via alias");
    rd_chk(8'h04, "R3 alias reads status");
    // R9: mask with byte enable on lane 1 only
    access(1'b1, 8'h08, 32'hFFFF_FFFF, 4'b0010, '0, '0, tmp);
    rd_chk(8'h08, "R9 mask byte lane");
    chk(irq === 1'b0, "R10 masked off", {31'd0, irq}, 0);
    access(1'b1, 8'h08, 32'hFFFF_FFFF, 4'b1111, '0, '0, tmp);
    chk(irq === 1'b1, "R10 irq raised", {31'd0, irq}, 1);
    // R4: clear only lane 0
    access(1'b1, 8'h00, 32'hFFFF_FFFF, 4'b0001, '0, '0, tmp);
    rd_chk(8'h00, "R4 clear lane 0 only");
    // R11: undecoded address
    access(1'b1, 8'h0C, 32'hFFFF_FFFF, 4'b1111, '0, '0, tmp);
    rd_chk(8'h00, "R11 status untouched");
    rd_chk(8'h08, "R11 mask untouched");
    rd_chk(8'h0C, "R3 unmapped reads zero");
    access(1'b1, 8'h01, 32'hFFFF_FFFF, 4'b1111, '0, '0, tmp);
    rd_chk(8'h00, "R11 unaligned write ignored");
    // R7: event on the commit edge of a full clear
    access(1'b1, 8'h04, 32'h0000_0008, 4'b1111, '0, '0, tmp);
    access(1'b1, 8'h00, 32'hFFFF_FFFF, 4'b1111, '0, 32'h0000_0008, tmp);
    rd_chk(8'h00, "R7 event beats clear");
    chk(irq === 1'b1, "R7 irq stays", {31'd0, irq}, 1);
    // R6 idle events
    idle(32'h8000_0000);
    rd_chk(8'h00, "R6 idle event captured");
    // R8 set alias: first cycle no change checked inside access
    access(1'b1, 8'h00, 32'hFFFF_FFFF, 4'b1111, '0, '0, tmp);
    chk(irq === 1'b0, "R4 all cleared", {31'd0, irq}, 0);
    access(1'b1, 8'h04, 32'h0001_0000, 4'b1111, '0, '0, tmp);
    rd_chk(8'h00, "R8 single set effect");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      logic [2:0] pick;
      pick = 3'($urandom_range(0, 4));
      case (pick)
        3'd0: a = 8'h00;
        3'd1: a = 8'h04;
        3'd2: a = 8'h08;
        3'd3: a = 8'h0C;
        default: a = 8'h10;
      endcase
      if (n % 7 == 3) idle($urandom & $urandom & $urandom);
      access(1'($urandom), a, $urandom, 4'($urandom),
             $urandom & $urandom & $urandom, $urandom & $urandom & $urandom, tmp);
    end
    rd_chk(8'h00, "R6 random status");
    rd_chk(8'h08, "R9 random mask");

    // R1: reset mid-run
    access(1'b1, 8'h04, 32'hFFFF_FFFF, 4'b1111, '0, '0, tmp);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_stat = '0; m_mask = '0;
    #1;
    chk(irq === 1'b0 && bus_ack === 1'b0, "R1 irq after reset", {31'd0, irq}, 0);
    rd_chk(8'h04, "R1 status cleared by reset");
    rd_chk(8'h08, "R1 mask cleared by reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule